// File: doc/BRIEF.md
# Compressed Machine-Mode CSR File

This block is the machine-level control and status register store of a small 32-bit integer core. The core presents a 12-bit register address, an operation code, a 5-bit source field and a source-register value together with a request strobe. One clock later the block returns the prior value of the addressed register and a flag that tells the core whether the access must trap. A legal, permitted write changes the register at the same clock edge.

Only seven registers have real storage, and most of their bits are tied to zero. Addresses are sorted into four classes:
- stored registers;
- read-zero registers where writes are quietly dropped;
- read-zero identity registers where writes trap;
- registers whose every access traps.

Any address not on a fixed list is folded onto a 4-bit physical index made of address bit 6 and address bits 2:0. The decode treats the rest of the address as don't-care, which keeps it small.

A separate trap-controller port applies the side effects of trap entry and trap return. The block exports the trap vector, the exception return address and a combined "interrupt may be taken" signal.

Top module: `mcsr_file`

## Requirements
- R1: A request sampled with `req_valid_i` high produces `rsp_valid_o` high one cycle later, with `rsp_rdata_o` and `rsp_illegal_o` valid in that cycle. A cycle with no request produces `rsp_valid_o` low one cycle later.
- R2: After reset, every stored field reads zero, except the trap vector. The trap vector reads `TVEC_RESET` with bits 1:0 cleared. `rsp_valid_o` is low during reset.
- R3: An address on none of the fixed lists in R4 to R6 is stored-class, with index {addr[6], addr[2:0]}. The index-to-register map is:

  | Index | Register |
  |---|---|
  | 0000 | status |
  | 0100 | interrupt enable |
  | 0101 | trap vector |
  | 1000 | scratch |
  | 1001 | exception PC |
  | 1010 | cause |
  | 1100 | interrupt pending |

  Any other index reads zero and ignores writes, without trapping.
- R4: Addresses 0xF11 to 0xF15 read zero. A request that would write them traps. A set or clear with a zero source is a legal read.
- R5: The following addresses read zero, ignore writes and never trap:
  - 0x301, 0x310, 0x320 and 0x343;
  - 0xB00 and 0xB02;
  - 0xB03 to 0xB1F;
  - 0x323 to 0x33F.
- R6: Every access to 0x302, 0x303, 0x306, 0x30A, 0x31A, 0x34A, 0x34B, 0x747 or 0x757 traps. On a trapping access `rsp_rdata_o` is zero and no state changes.
- R7: `req_funct_i[1:0]` selects the operation: 01 writes the operand, 10 sets the operand's one bits, 11 clears them, and 00 traps. `req_funct_i[2]`=1 makes the operand the zero-extended `req_src_i`; otherwise the operand is `req_rs1_val_i`. The read data is the value before the update.
- R8: A set or clear with `req_src_i`=0 does not write. A write operation always writes.
- R9: In the status register, only bits 12:11, 7 and 3 are stored; all other bits read zero.
- R10: In the interrupt-enable register, only bit 11 is stored. The pending register reads `irq_ext_i` in bit 11 and zero elsewhere, and writes to it have no effect.
- R11: In the trap vector and the exception PC, bits 1:0 read zero, both through a CSR read and on `tvec_o` and `epc_o`.
- R12: `trap_enter_i` loads the exception PC from `trap_pc_i` and the cause from `trap_cause_i`, copies bit 3 of status into bit 7, and clears bit 3. `trap_return_i` copies bit 7 into bit 3, sets bit 7 and sets bits 12:11 to 11. Trap updates win over a CSR write in the same cycle.
- R13: `irq_pending_o` is high exactly when status bit 3, interrupt-enable bit 11 and `irq_ext_i` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | 12 | Register address |
| req_funct_i | input | 3 | Operation: bit 2 immediate form, bits 1:0 operation |
| req_src_i | input | 5 | Source register index or immediate |
| req_rs1_val_i | input | 32 | Source register value |
| rsp_valid_o | output | 1 | Response valid |
| rsp_illegal_o | output | 1 | Access must trap |
| rsp_rdata_o | output | 32 | Prior register value |
| irq_ext_i | input | 1 | External interrupt line |
| trap_enter_i | input | 1 | Trap entry update |
| trap_pc_i | input | 32 | PC saved on trap entry |
| trap_cause_i | input | 32 | Cause saved on trap entry |
| trap_return_i | input | 1 | Trap return update |
| tvec_o | output | 32 | Trap vector address |
| epc_o | output | 32 | Exception return address |
| irq_pending_o | output | 1 | Enabled external interrupt present |

## Verification
The bench builds the block with `TVEC_RESET` = 0x103. This makes the reset read of the trap vector distinguish a correct reset value (0x100) from a missing reset load or from unmasked mode bits. Random addresses drawn from every fixed list and from unlisted aliases are mixed with all eight operation codes and zero and non-zero sources. This reaches each legality class under writes, sets, clears and pure reads.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;
    localparam int SRC_W  = 5;
    localparam int IDX_W  = 4;

    localparam int ST_MIE  = 3;
    localparam int ST_MPIE = 7;
    localparam int ST_MPP  = 11;
    localparam int EXT_BIT = 11;

    localparam logic [IDX_W-1:0] IX_STATUS  = 4'b0000;
    localparam logic [IDX_W-1:0] IX_ENABLE  = 4'b0100;
    localparam logic [IDX_W-1:0] IX_VECTOR  = 4'b0101;
    localparam logic [IDX_W-1:0] IX_SCRATCH = 4'b1000;
    localparam logic [IDX_W-1:0] IX_EPC     = 4'b1001;
    localparam logic [IDX_W-1:0] IX_CAUSE   = 4'b1010;
    localparam logic [IDX_W-1:0] IX_PENDING = 4'b1100;

    typedef enum logic [1:0] {
        CL_STORE    = 2'd0,
        CL_ZERO_IGN = 2'd1,
        CL_ZERO_RO  = 2'd2,
        CL_DENY     = 2'd3
    } csr_class_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
    } status_t;

    typedef struct packed {
        status_t           status;
        logic              ext_en;
        logic [XLEN-3:0]   vec_base;
        logic [XLEN-1:0]   scratch;
        logic [XLEN-3:0]   epc_word;
        logic [XLEN-1:0]   cause;
        logic              rsp_valid;
        logic              rsp_illegal;
        logic [XLEN-1:0]   rsp_rdata;
    } state_t;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output csr_class_e        class_o,
    output logic [IDX_W-1:0]  index_o
);
    always_comb begin
        index_o = {addr_i[6], addr_i[2:0]};
        if (addr_i >= 12'hF11 && addr_i <= 12'hF15) begin
            class_o = CL_ZERO_RO;
        end else if (addr_i == 12'h301 || addr_i == 12'h310 || addr_i == 12'h320 ||
                     addr_i == 12'h343 || addr_i == 12'hB00 || addr_i == 12'hB02 ||
                     (addr_i >= 12'hB03 && addr_i <= 12'hB1F) ||
                     (addr_i >= 12'h323 && addr_i <= 12'h33F)) begin
            class_o = CL_ZERO_IGN;
        end else if (addr_i == 12'h302 || addr_i == 12'h303 || addr_i == 12'h306 ||
                     addr_i == 12'h30A || addr_i == 12'h31A || addr_i == 12'h34A ||
                     addr_i == 12'h34B || addr_i == 12'h747 || addr_i == 12'h757) begin
            class_o = CL_DENY;
        end else begin
            class_o = CL_STORE;
        end
    end
endmodule

// File: rtl/mcsr_modify.sv
module mcsr_modify
    import mcsr_pkg::*;
(
    input  csr_op_e         op_i,
    input  logic            src_zero_i,
    input  logic [XLEN-1:0] operand_i,
    input  logic [XLEN-1:0] old_i,
    output logic [XLEN-1:0] new_o,
    output logic            wr_o
);
    always_comb begin
        new_o = old_i;
        wr_o  = 1'b0;
        case (op_i)
            OP_WRITE: begin new_o = operand_i;           wr_o = 1'b1;        end
            OP_SET:   begin new_o = old_i | operand_i;   wr_o = !src_zero_i; end
            OP_CLEAR: begin new_o = old_i & ~operand_i;  wr_o = !src_zero_i; end
            default:  begin new_o = old_i;               wr_o = 1'b0;        end
        endcase
    end
endmodule

// File: rtl/mcsr_readmux.sv
module mcsr_readmux
    import mcsr_pkg::*;
(
    input  state_t           st_i,
    input  logic             irq_i,
    input  csr_class_e       class_i,
    input  logic [IDX_W-1:0] index_i,
    output logic [XLEN-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (class_i == CL_STORE) begin
            case (index_i)
                IX_STATUS: begin
                    rdata_o[ST_MPP+1:ST_MPP] = st_i.status.mpp;
                    rdata_o[ST_MPIE]         = st_i.status.mpie;
                    rdata_o[ST_MIE]          = st_i.status.mie;
                end
                IX_ENABLE:  rdata_o[EXT_BIT] = st_i.ext_en;
                IX_VECTOR:  rdata_o = {st_i.vec_base, 2'b00};
                IX_SCRATCH: rdata_o = st_i.scratch;
                IX_EPC:     rdata_o = {st_i.epc_word, 2'b00};
                IX_CAUSE:   rdata_o = st_i.cause;
                IX_PENDING: rdata_o[EXT_BIT] = irq_i;
                default:    rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
    import mcsr_pkg::*;
#(
    parameter logic [XLEN-1:0] TVEC_RESET = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [2:0]        req_funct_i,
    input  logic [SRC_W-1:0]  req_src_i,
    input  logic [XLEN-1:0]   req_rs1_val_i,
    output logic              rsp_valid_o,
    output logic              rsp_illegal_o,
    output logic [XLEN-1:0]   rsp_rdata_o,
    input  logic              irq_ext_i,
    input  logic              trap_enter_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic [XLEN-1:0]   trap_cause_i,
    input  logic              trap_return_i,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              irq_pending_o
);
    state_t            st_d, st_q;
    csr_class_e        cls;
    logic [IDX_W-1:0]  idx;
    csr_op_e           op;
    logic [XLEN-1:0]   operand, cur_val, new_val;
    logic              src_zero, wr_req, illegal, commit;
    logic [1:0]        unused_pc_lsb;

    assign unused_pc_lsb = trap_pc_i[1:0];
    assign op       = csr_op_e'(req_funct_i[1:0]);
    assign src_zero = (req_src_i == '0);
    assign operand  = req_funct_i[2] ? {{(XLEN-SRC_W){1'b0}}, req_src_i} : req_rs1_val_i;

    mcsr_decode  i_decode (.addr_i(req_addr_i), .class_o(cls), .index_o(idx));

    mcsr_readmux i_read (.st_i(st_q), .irq_i(irq_ext_i), .class_i(cls),
                         .index_i(idx), .rdata_o(cur_val));

    mcsr_modify  i_mod (.op_i(op), .src_zero_i(src_zero), .operand_i(operand),
                        .old_i(cur_val), .new_o(new_val), .wr_o(wr_req));

    assign illegal = (op == OP_NONE) || (cls == CL_DENY) || (cls == CL_ZERO_RO && wr_req);
    assign commit  = req_valid_i && !illegal && (cls == CL_STORE) && wr_req;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (idx)
                IX_STATUS: begin
                    st_d.status.mpp  = new_val[ST_MPP+1:ST_MPP];
                    st_d.status.mpie = new_val[ST_MPIE];
                    st_d.status.mie  = new_val[ST_MIE];
                end
                IX_ENABLE:  st_d.ext_en   = new_val[EXT_BIT];
                IX_VECTOR:  st_d.vec_base = new_val[XLEN-1:2];
                IX_SCRATCH: st_d.scratch  = new_val;
                IX_EPC:     st_d.epc_word = new_val[XLEN-1:2];
                IX_CAUSE:   st_d.cause    = new_val;
                default:    st_d.cause    = st_q.cause;
            endcase
        end
        if (trap_enter_i) begin
            st_d.epc_word    = trap_pc_i[XLEN-1:2];
            st_d.cause       = trap_cause_i;
            st_d.status.mpie = st_d.status.mie;
            st_d.status.mie  = 1'b0;
        end else if (trap_return_i) begin
            st_d.status.mie  = st_d.status.mpie;
            st_d.status.mpie = 1'b1;
            st_d.status.mpp  = 2'b11;
        end
        st_d.rsp_valid   = req_valid_i;
        st_d.rsp_illegal = req_valid_i && illegal;
        st_d.rsp_rdata   = (req_valid_i && !illegal) ? cur_val : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.vec_base <= TVEC_RESET[XLEN-1:2];
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o   = st_q.rsp_valid;
    assign rsp_illegal_o = st_q.rsp_illegal;
    assign rsp_rdata_o   = st_q.rsp_rdata;
    assign tvec_o        = {st_q.vec_base, 2'b00};
    assign epc_o         = {st_q.epc_word, 2'b00};
    assign irq_pending_o = st_q.status.mie && st_q.ext_en && irq_ext_i;
endmodule

// File: rtl/mcsr_checker.sv
module mcsr_checker
    import mcsr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [2:0]        req_funct_i,
    input logic              rsp_valid_o,
    input logic              rsp_illegal_o,
    input logic [XLEN-1:0]   rsp_rdata_o,
    input logic              irq_ext_i,
    input logic              trap_enter_i,
    input logic [XLEN-1:0]   trap_pc_i,
    input logic [XLEN-1:0]   epc_o,
    input logic              irq_pending_o
);
    a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    a_r1_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    a_r6_illegal_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_illegal_o |-> (rsp_valid_o && rsp_rdata_o == '0));

    a_r4_id_write_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_addr_i >= 12'hF11 && req_addr_i <= 12'hF15 &&
         req_funct_i[1:0] == 2'b01) |=> rsp_illegal_o);

    a_r12_trap_loads_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_enter_i |=> (epc_o == {$past(trap_pc_i[XLEN-1:2]), 2'b00}));

    a_r12_trap_masks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_enter_i |=> !irq_pending_o);

    a_r13_pending_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_pending_o |-> irq_ext_i);
endmodule

bind mcsr_file mcsr_checker i_mcsr_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .req_funct_i(req_funct_i),
    .rsp_valid_o(rsp_valid_o), .rsp_illegal_o(rsp_illegal_o),
    .rsp_rdata_o(rsp_rdata_o), .irq_ext_i(irq_ext_i),
    .trap_enter_i(trap_enter_i), .trap_pc_i(trap_pc_i),
    .epc_o(epc_o), .irq_pending_o(irq_pending_o)
);

// File: tb/test_mcsr_file.sv
module test_mcsr_file;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RESET_VEC = 32'h0000_0103;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_funct = '0;
    logic [4:0]  req_src = '0;
    logic [31:0] req_rs1 = '0;
    logic        rsp_valid, rsp_illegal;
    logic [31:0] rsp_rdata, tvec, epc;
    logic        irq = 1'b0, t_enter = 1'b0, t_ret = 1'b0, pend;
    logic [31:0] t_pc = '0, t_cause = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [1:0]  m_mpp;
    logic        m_mpie, m_mie, m_meie;
    logic [31:0] m_vec, m_scratch, m_epc, m_cause;

    mcsr_file #(.TVEC_RESET(RESET_VEC)) i_mcsr_file (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_funct_i(req_funct), .req_src_i(req_src), .req_rs1_val_i(req_rs1),
        .rsp_valid_o(rsp_valid), .rsp_illegal_o(rsp_illegal), .rsp_rdata_o(rsp_rdata),
        .irq_ext_i(irq), .trap_enter_i(t_enter), .trap_pc_i(t_pc),
        .trap_cause_i(t_cause), .trap_return_i(t_ret), .tvec_o(tvec), .epc_o(epc),
        .irq_pending_o(pend));

    always #(CLK_PERIOD/2) clk = ~clk;

    // 0 stored, 1 zero/ignored, 2 zero/write traps, 3 always traps
    function automatic int cls_of(input logic [11:0] a);
        if (a >= 12'hF11 && a <= 12'hF15) return 2;
        if (a == 12'h301 || a == 12'h310 || a == 12'h320 || a == 12'h343 ||
            a == 12'hB00 || a == 12'hB02 || (a >= 12'hB03 && a <= 12'hB1F) ||
            (a >= 12'h323 && a <= 12'h33F)) return 1;
        if (a == 12'h302 || a == 12'h303 || a == 12'h306 || a == 12'h30A ||
            a == 12'h31A || a == 12'h34A || a == 12'h34B || a == 12'h747 ||
            a == 12'h757) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (cls_of(a) != 0) return 32'h0;
        case ({a[6], a[2:0]})
            4'b0000: return (32'(m_mpp) << 11) | (32'(m_mpie) << 7) | (32'(m_mie) << 3);
            4'b0100: return 32'(m_meie) << 11;
            4'b0101: return m_vec & 32'hFFFF_FFFC;
            4'b1000: return m_scratch;
            4'b1001: return m_epc & 32'hFFFF_FFFC;
            4'b1010: return m_cause;
            4'b1100: return 32'(irq) << 11;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [11:0] pick_addr(input int i);
        case (i)
            0: return 12'h300;  1: return 12'h304;  2: return 12'h305;  3: return 12'h340;
            4: return 12'h341;  5: return 12'h342;  6: return 12'h344;  7: return 12'hF11;
            8: return 12'hF14;  9: return 12'hF15; 10: return 12'h301; 11: return 12'h310;
            12: return 12'h320; 13: return 12'h343; 14: return 12'hB00; 15: return 12'hB02;
            16: return 12'hB1F; 17: return 12'h323; 18: return 12'h33F; 19: return 12'h302;
            20: return 12'h34A; 21: return 12'h757; 22: return 12'h747; default: return 12'h31A;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input string tag, input logic [11:0] a, input logic [2:0] f,
                          input logic [4:0] s, input logic [31:0] v);
        logic [31:0] opnd, old, nv;
        logic        wr, ill;
        int          c;
        c    = cls_of(a);
        opnd = f[2] ? {27'h0, s} : v;
        old  = model_read(a);
        wr   = (f[1:0] == 2'b01) || (f[1:0] != 2'b00 && s != 0);
        ill  = (f[1:0] == 2'b00) || (c == 3) || (c == 2 && wr);
        case (f[1:0])
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            default: nv = old & ~opnd;
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_funct = f; req_src = s; req_rs1 = v;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_illegal !== ill || rsp_rdata !== (ill ? 32'h0 : old)) begin
            fails++;
            $display("FAIL %s addr=%h funct=%b actual v=%b ill=%b d=%h expected v=1 ill=%b d=%h",
                     tag, a, f, rsp_valid, rsp_illegal, rsp_rdata, ill, ill ? 32'h0 : old);
        end
        if (!ill && c == 0 && wr) begin
            case ({a[6], a[2:0]})
                4'b0000: begin m_mpp = nv[12:11]; m_mpie = nv[7]; m_mie = nv[3]; end
                4'b0100: m_meie = nv[11];
                4'b0101: m_vec = nv;
                4'b1000: m_scratch = nv;
                4'b1001: m_epc = nv;
                4'b1010: m_cause = nv;
                default: ;
            endcase
        end
    endtask

    task automatic trap_in(input logic [31:0] pc, input logic [31:0] cause);
        @(negedge clk);
        t_enter = 1'b1; t_pc = pc; t_cause = cause;
        @(negedge clk);
        t_enter = 1'b0;
        m_epc = pc; m_cause = cause; m_mpie = m_mie; m_mie = 1'b0;
        check("R12 trap epc", epc, pc & 32'hFFFF_FFFC);
    endtask

    task automatic trap_out();
        @(negedge clk);
        t_ret = 1'b1;
        @(negedge clk);
        t_ret = 1'b0;
        m_mie = m_mpie; m_mpie = 1'b1; m_mpp = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_mpp = 0; m_mpie = 0; m_mie = 0; m_meie = 0;
        m_vec = RESET_VEC; m_scratch = 0; m_epc = 0; m_cause = 0;
        repeat (3) @(negedge clk);
        check("R2 valid low in reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        check("R2 reset tvec_o", tvec, 32'h0000_0100);
        access("R2 reset vector read", 12'h305, 3'b010, 5'd0, 32'h0);
        access("R2 reset status read", 12'h300, 3'b010, 5'd0, 32'h0);
        @(negedge clk);
        check("R1 idle gives no response", {31'h0, rsp_valid}, 32'h0);

        access("R9 status all ones", 12'h300, 3'b001, 5'd1, 32'hFFFF_FFFF);
        access("R9 status masked read", 12'h300, 3'b010, 5'd0, 32'h0);
        access("R10 enable all ones", 12'h304, 3'b001, 5'd1, 32'hFFFF_FFFF);
        access("R10 enable masked read", 12'h304, 3'b010, 5'd0, 32'h0);
        irq = 1'b1;
        access("R10 pending write ignored", 12'h344, 3'b001, 5'd1, 32'h0);
        access("R10 pending follows line", 12'h344, 3'b010, 5'd0, 32'h0);
        @(negedge clk);
        check("R13 pending asserted", {31'h0, pend}, 32'h1);
        irq = 1'b0;
        @(negedge clk);
        check("R13 pending drops with line", {31'h0, pend}, 32'h0);
        access("R11 vector low bits", 12'h305, 3'b001, 5'd1, 32'hFFFF_FFFF);
        access("R11 vector read", 12'h305, 3'b010, 5'd0, 32'h0);
        check("R11 tvec_o", tvec, 32'hFFFF_FFFC);
        access("R11 epc low bits", 12'h341, 3'b001, 5'd1, 32'h1234_5677);
        access("R11 epc read", 12'h341, 3'b010, 5'd0, 32'h0);
        check("R11 epc_o", epc, 32'h1234_5674);
        access("R7 scratch write", 12'h340, 3'b001, 5'd3, 32'hA5A5_0000);
        access("R7 immediate set", 12'h340, 3'b110, 5'd5, 32'hFFFF_FFFF);
        access("R7 register clear", 12'h340, 3'b011, 5'd7, 32'hA000_0001);
        access("R8 clear with zero source", 12'h340, 3'b011, 5'd0, 32'hFFFF_FFFF);
        access("R8 set-imm zero source", 12'h340, 3'b110, 5'd0, 32'h0);
        access("R7 opcode 00 traps", 12'h340, 3'b000, 5'd1, 32'h0);
        access("R7 opcode 100 traps", 12'h340, 3'b100, 5'd1, 32'h0);
        access("R3 alias of scratch", 12'h7C0, 3'b010, 5'd0, 32'h0);
        access("R3 alias write", 12'hBC8, 3'b001, 5'd2, 32'h0BAD_F00D);
        access("R3 scratch after alias", 12'h340, 3'b010, 5'd0, 32'h0);
        access("R3 unused index write", 12'h307, 3'b001, 5'd1, 32'hFFFF_FFFF);
        access("R3 unused index read", 12'h307, 3'b010, 5'd0, 32'h0);
        access("R4 id read legal", 12'hF11, 3'b010, 5'd0, 32'h0);
        access("R4 id write traps", 12'hF14, 3'b001, 5'd0, 32'h0);
        access("R4 id set traps", 12'hF15, 3'b110, 5'd4, 32'h0);
        access("R5 ignored write", 12'h301, 3'b001, 5'd1, 32'hFFFF_FFFF);
        access("R5 ignored range", 12'hB1F, 3'b010, 5'd3, 32'hFFFF_FFFF);
        access("R6 denied read", 12'h302, 3'b010, 5'd0, 32'h0);
        access("R6 denied write", 12'h757, 3'b001, 5'd1, 32'h1);
        access("R6 scratch unchanged", 12'h340, 3'b010, 5'd0, 32'h0);

        access("R12 enable irq", 12'h300, 3'b110, 5'd8, 32'h0);
        trap_in(32'h8000_0123, 32'h8000_000B);
        access("R12 cause read", 12'h342, 3'b010, 5'd0, 32'h0);
        access("R12 status after entry", 12'h300, 3'b010, 5'd0, 32'h0);
        trap_out();
        access("R12 status after return", 12'h300, 3'b010, 5'd0, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [4:0]  s;
            int          sel;
            sel = int'($urandom % 32);
            a = (sel < 24) ? pick_addr(sel) : 12'($urandom);
            s = (($urandom % 4) == 0) ? 5'd0 : 5'($urandom);
            if (($urandom % 8) == 0) irq = ~irq;
            if (($urandom % 50) == 0) trap_in($urandom, $urandom);
            else if (($urandom % 50) == 0) trap_out();
            case (cls_of(a))
                0:       access("R3 random stored", a, 3'($urandom), s, $urandom);
                1:       access("R5 random ignored", a, 3'($urandom), s, $urandom);
                2:       access("R4 random id", a, 3'($urandom), s, $urandom);
                default: access("R6 random denied", a, 3'($urandom), s, $urandom);
            endcase
            @(negedge clk);
            check("R13 pending random", {31'h0, pend}, {31'h0, m_mie & m_meie & irq});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule